// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets a host processor reach a 128-entry byte register file over a two-wire I2C bus. It watches the SCL and SDA lines with a fast system clock, passes each through a short synchroniser, and finds START, repeated START and STOP conditions from the synchronised levels. When the address byte names this device, the block acknowledges. It then takes a register pointer from the first byte of a write and moves bytes between the bus and the register file, stepping the pointer after every byte.

The register file sits outside the block behind a plain port: a 7-bit address, which is the live pointer; write data with a one-cycle write strobe; and read data returned combinationally for the current address. The bus side is an open-drain style output that is high whenever the block wants SDA pulled low. A strap input picks the lowest address bit, so two such devices can share one bus. An enable input switches the bus engine off entirely, so that other traffic on the shared wires is never taken for I2C.

A read follows the usual pattern. The host writes the pointer, issues a repeated START, addresses the device with the read bit set, and then ACKs every byte it wants to continue with. It ends the read with a NACK and then a STOP.

Top module: `i2c_reg_slave`

## Requirements
- R1: The device address is the 7 bits {110100, addr_sel}. The address byte carries it in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). On a match the block pulls SDA low during the ninth clock.
- R2: After an address byte that does not match, the block never drives SDA and never pulses reg_we, and reg_addr keeps its value until the next START or repeated START.
- R3: A START (SDA falls while SCL is high) or a repeated START begins a new address phase from any state. A STOP (SDA rises while SCL is high) releases SDA and returns the block to idle. After reset SDA is released, reg_we is low and reg_addr is 0.
- R4: In a write, the byte after the address loads the pointer from its low 7 bits (bit 7 is ignored), and the block ACKs that byte.
- R5: Each later write byte is ACKed and produces a one-cycle reg_we with reg_wdata equal to the byte and reg_addr equal to the pointer. The pointer then steps by one.
- R6: The pointer steps from 0x7F to 0x00.
- R7: After address plus read bit, the block sends the byte at the pointer MSB first. It changes SDA only while SCL is low, and the pointer steps by one each time a byte is loaded for sending.
- R8: A host ACK after a read byte makes the block send the byte at the stepped pointer. After a host NACK the block leaves SDA released until the next START. A read with no pointer phase continues from the current pointer.
- R9: While bus_en is low the block releases SDA, ACKs nothing and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | 1 enables the I2C engine; 0 holds it idle |
| addr_sel | input | 1 | Lowest bit of the device address |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_addr | output | 7 | Register file address (current pointer) |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | One-cycle register file write strobe |
| reg_rdata | input | 8 | Register file read data for reg_addr |

## Verification
Each edge at scl_in or sda_in reaches the engine after two synchroniser flops and acts at the third clock edge, so sda_drive_low and reg_we move three system clocks after the pin change. The host model therefore holds every SCL phase for six clocks, drives inputs on falling clock edges, and samples SDA at the middle of the SCL high phase, well after the slave's ACK or data bit has settled. The write strobe comes at the SCL fall after the eighth data bit. Strobe counts, pointer values and memory contents are therefore checked only after the STOP and a few idle clocks, when no update can still be pending.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_HACK,
    ST_SKIP
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {(STAGES + 1){RST_VAL}};
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int          AW         = 7,
  parameter logic [5:0]  DEV_PREFIX = 6'b110100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              addr_sel,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_drive_low,
  output logic [AW-1:0]     reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we
);
  localparam logic [AW-1:0] ONE      = AW'(1);
  localparam logic [3:0]    BITS     = 4'(BYTE_W);
  localparam logic [3:0]    LAST_BIT = 4'(BYTE_W - 1);

  i2cs_state_e        state, ret_st;
  logic [BYTE_W-1:0]  sh;
  logic [3:0]         cnt;
  logic [AW-1:0]      ptr;
  logic               hack_ok;

  logic start_evt, stop_evt, addr_hit;
  assign start_evt = sda_fall & scl_lvl;
  assign stop_evt  = sda_rise & scl_lvl;
  assign addr_hit  = (sh[BYTE_W-1:1] == {DEV_PREFIX, addr_sel});
  assign reg_addr  = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      ret_st        <= ST_IDLE;
      sh            <= '0;
      cnt           <= '0;
      ptr           <= '0;
      hack_ok       <= 1'b0;
      sda_drive_low <= 1'b0;
      reg_we        <= 1'b0;
      reg_wdata     <= '0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) ptr <= ptr + ONE;
      if (!bus_en) begin
        state         <= ST_IDLE;
        sda_drive_low <= 1'b0;
      end else if (start_evt) begin
        state         <= ST_ADDR;
        cnt           <= '0;
        sda_drive_low <= 1'b0;
      end else if (stop_evt) begin
        state         <= ST_IDLE;
        sda_drive_low <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == BITS) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sda_drive_low <= 1'b1;
                  state         <= ST_ACK;
                  ret_st        <= sh[0] ? ST_RDATA : ST_PTR;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_PTR) begin
                ptr           <= sh[AW-1:0];
                sda_drive_low <= 1'b1;
                state         <= ST_ACK;
                ret_st        <= ST_WDATA;
              end else begin
                reg_wdata     <= sh;
                reg_we        <= 1'b1;
                sda_drive_low <= 1'b1;
                state         <= ST_ACK;
                ret_st        <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (ret_st == ST_RDATA) begin
                sh            <= reg_rdata;
                sda_drive_low <= ~reg_rdata[BYTE_W-1];
                ptr           <= ptr + ONE;
                state         <= ST_RDATA;
              end else begin
                sda_drive_low <= 1'b0;
                state         <= ret_st;
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_drive_low <= 1'b0;
                state         <= ST_HACK;
              end else begin
                sh            <= {sh[BYTE_W-2:0], 1'b0};
                sda_drive_low <= ~sh[BYTE_W-2];
                cnt           <= cnt + 4'd1;
              end
            end
          end
          ST_HACK: begin
            if (scl_rise) begin
              hack_ok <= ~sda_lvl;
            end else if (scl_fall) begin
              cnt <= '0;
              if (hack_ok) begin
                sh            <= reg_rdata;
                sda_drive_low <= ~reg_rdata[BYTE_W-1];
                ptr           <= ptr + ONE;
                state         <= ST_RDATA;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5: the write strobe is a single-cycle pulse
  a_r5_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R6: after a write the pointer steps by one, wrapping at the top
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == $past(reg_addr) + ONE));

  // R7: the slave changes SDA only while SCL is low
  a_r7_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !$stable(sda_drive_low)) |-> !scl_lvl);

  // R3: a STOP always leaves SDA released
  a_r3_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_drive_low);

  // R9: a disabled engine never drives the bus
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> (!sda_drive_low && !reg_we));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2cs_pkg::*;
#(
  parameter int         DEPTH       = 128,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_PREFIX  = 6'b110100,
  localparam int        AW          = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              addr_sel,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_drive_low,
  output logic [AW-1:0]     reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  // index 0 = SCL, index 1 = SDA
  logic [1:0] raw, lvl, rise, fall;
  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[g]),
      .lvl  (lvl[g]),
      .rise (rise[g]),
      .fall (fall[g])
    );
  end

  i2cs_engine #(.AW(AW), .DEV_PREFIX(DEV_PREFIX)) u_engine (
    .clk           (clk),
    .rst           (rst),
    .bus_en        (bus_en),
    .addr_sel      (addr_sel),
    .scl_lvl       (lvl[0]),
    .scl_rise      (rise[0]),
    .scl_fall      (fall[0]),
    .sda_lvl       (lvl[1]),
    .sda_rise      (rise[1]),
    .sda_fall      (fall[1]),
    .reg_rdata     (reg_rdata),
    .sda_drive_low (sda_drive_low),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_we        (reg_we)
  );
endmodule

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b1;
  logic       addr_sel = 1'b0;
  logic       scl_drv = 1'b1;
  logic       host_sda = 1'b1;
  logic       sda_drive_low;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_we;
  wire        sda_line = host_sda & ~sda_drive_low;

  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [6:0] exp_ptr;
  int         we_count;
  int         vectors = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  i2c_reg_slave uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .addr_sel(addr_sel),
    .scl_in(scl_drv), .sda_in(sda_line), .sda_drive_low(sda_drive_low),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  // register file attached to the block's port
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 128; k++) mem[k] <= 8'h00;
      we_count <= 0;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_count <= we_count + 1;
    end
  end

  function automatic logic dev_ok(input logic [6:0] dev);
    return bus_en && (dev == {6'b110100, addr_sel});
  endfunction

  task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    host_sda = 1'b0; tick(Q); scl_drv = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart;
    host_sda = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
    host_sda = 1'b0; tick(Q); scl_drv = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    host_sda = 1'b0; tick(Q); scl_drv = 1'b1; tick(Q); host_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    host_sda = b; tick(Q); scl_drv = 1'b1; tick(2 * Q); scl_drv = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    host_sda = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
    b = sda_line; tick(Q); scl_drv = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack);
  endtask

  task automatic write_burst(input logic [6:0] dev, input logic [7:0] p,
                             input int n, input string tag);
    logic ok, ack;
    logic [7:0] d;
    int base;
    ok = dev_ok(dev);
    base = we_count;
    bus_start;
    put_byte({dev, 1'b0}, ack);
    chk({tag, " address ack"}, 32'(ack), 32'(ok));
    put_byte(p, ack);
    chk({tag, " pointer ack"}, 32'(ack), 32'(ok));
    if (ok) exp_ptr = p[6:0];
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      put_byte(d, ack);
      chk({tag, " data ack"}, 32'(ack), 32'(ok));
      if (ok) begin
        exp_mem[exp_ptr] = d;
        exp_ptr = exp_ptr + 7'd1;
      end
    end
    bus_stop;
    tick(4);
    chk({tag, " write strobes"}, 32'(we_count - base), ok ? 32'(n) : 32'd0);
    chk({tag, " pointer after write"}, 32'(reg_addr), 32'(exp_ptr));
    chk({tag, " sda released after stop R3"}, 32'(sda_drive_low), 32'd0);
  endtask

  task automatic read_burst(input logic [6:0] dev, input logic set_ptr,
                            input logic [7:0] p, input int n, input string tag);
    logic ok, ack;
    logic [7:0] d;
    ok = dev_ok(dev);
    bus_start;
    if (set_ptr) begin
      put_byte({dev, 1'b0}, ack);
      chk({tag, " address ack"}, 32'(ack), 32'(ok));
      put_byte(p, ack);
      chk({tag, " pointer ack"}, 32'(ack), 32'(ok));
      if (ok) exp_ptr = p[6:0];
      bus_rstart;
    end
    put_byte({dev, 1'b1}, ack);
    chk({tag, " read address ack"}, 32'(ack), 32'(ok));
    if (ok) begin
      for (int i = 0; i < n; i++) begin
        get_byte(d, i != n - 1);
        chk({tag, " read data"}, 32'(d), 32'(exp_mem[exp_ptr]));
        exp_ptr = exp_ptr + 7'd1;
      end
    end
    get_byte(d, 1'b0);
    chk({tag, " bus silent R8"}, 32'(d), 32'hFF);
    bus_stop;
    tick(4);
    chk({tag, " pointer after read"}, 32'(reg_addr), 32'(exp_ptr));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    for (int k = 0; k < 128; k++) exp_mem[k] = 8'h00;
    exp_ptr = 7'd0;
    tick(10);
    rst = 1'b0;
    tick(5);
    // R3 reset state
    chk("R3 reset sda", 32'(sda_drive_low), 32'd0);
    chk("R3 reset we", 32'(reg_we), 32'd0);
    chk("R3 reset addr", 32'(reg_addr), 32'd0);

    // R1, R5: basic burst write at 0x68 then read back via repeated START (R3, R7)
    write_burst(7'h68, 8'h10, 4, "R5");
    read_burst(7'h68, 1'b1, 8'h10, 4, "R7");

    // R6: wrap from 0x7F to 0x00 on write and read
    write_burst(7'h68, 8'h7E, 3, "R6");
    read_burst(7'h68, 1'b1, 8'h7E, 3, "R6");

    // R4: pointer byte bit 7 ignored
    write_burst(7'h68, 8'h85, 1, "R4");
    read_burst(7'h68, 1'b1, 8'h05, 1, "R4");

    // R8: read without pointer phase continues from current pointer
    read_burst(7'h68, 1'b0, 8'h00, 2, "R8");

    // R2: wrong address ignored
    write_burst(7'h69, 8'h20, 3, "R2");
    read_burst(7'h69, 1'b1, 8'h20, 2, "R2");

    // R1: strap selects the other address
    addr_sel = 1'b1;
    tick(4);
    write_burst(7'h69, 8'h30, 2, "R1");
    read_burst(7'h69, 1'b1, 8'h30, 2, "R1");
    write_burst(7'h68, 8'h31, 2, "R2");

    // R9: disabled engine ignores a matching transaction
    bus_en = 1'b0;
    tick(4);
    write_burst(7'h69, 8'h30, 2, "R9");
    bus_en = 1'b1;
    tick(4);
    read_burst(7'h69, 1'b1, 8'h30, 2, "R9");

    // random mix
    addr_sel = 1'b0;
    tick(4);
    for (int it = 0; it < 14; it++) begin
      logic [7:0] p;
      logic [6:0] dev;
      int n;
      n   = 1 + int'($urandom % 5);
      p   = 8'($urandom);
      dev = ($urandom % 4 == 0) ? 7'h6A : 7'h68;
      write_burst(dev, p, n, "R5");
      read_burst(7'h68, 1'b1, p, n, "R8");
    end

    // R5: register file contents match the model
    for (int k = 0; k < 128; k++) begin
      if (mem[k] !== exp_mem[k]) begin
        fails++;
        $display("FAIL R5 mem[%0d] actual=%0h expected=%0h", k, mem[k], exp_mem[k]);
      end
    end
    vectors++;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule